// File: doc/BRIEF.md
# Stored Bit Pattern Generator

The block replays a binary sequence kept in an on-chip word memory as a serial stream, one bit per qualified tick of an externally supplied rate enable. A host loads the pattern memory one 32-bit word at a time. It then programs the index of the last bit in the sequence, the bit index at which a scope trigger should fire, and a divisor that spreads each bit over several enable pulses. Once the run input is raised, the stream advances bit by bit and wraps back to bit zero after the last index. A trigger output marks the chosen bit on every pass, so any position inside the pattern can be lined up on an oscilloscope.

A pseudo-noise mode replaces the stored data with the output of a maximal-length Galois shift register, while the same index counter still drives wrap and trigger placement. Length and trigger offset may be rewritten during playback and are applied on the next pass. Divisor, mode and seed are only taken while the generator is stopped.

Top module: `bitpat_gen`

## Requirements
- R1: While and right after reset, `bit_valid`, `sync_out` and `bit_out` are 0.
- R2: In memory mode, bit index i is taken from word i/32 of the pattern memory at bit position i%32 (least significant bit first). Indices are played in rising order 0,1,...,L, where L is the last-index register, and play then restarts at 0.
- R3: With divisor D, every (D+1)-th `rate_en` pulse seen while `run` is 1 emits one bit. The emitted bit appears on `bit_out` one clock after the qualifying pulse, and `bit_valid` is 1 for exactly that clock. Pulses that emit no bit leave `bit_valid` at 0.
- R4: `sync_out` is 1 for the whole bit period of the bit whose index equals the sync-offset register, once per pass. It is never 1 when that offset is greater than L.
- R5: Writes to the last-index or sync-offset register during playback do not change the current pass. They take effect starting with the pass that follows the emission of index L.
- R6: In pseudo-noise mode the emitted bit is bit 0 of a 16-bit state S, after which S becomes (S>>1) XOR (S[0] ? 16'hB400 : 0). S is loaded from the seed register while stopped, and a seed of 0 is loaded as 1.
- R7: The divisor, mode and seed registers are sampled only while `run` is 0. Writes to them during playback change neither the bit rate nor the bit source.
- R8: While `run` is 0, `rate_en` is ignored, `bit_valid` and `sync_out` are 0 one clock later, and the next playback starts again at index 0.
- R9: Configuration is written with `cfg_we`, addressed by `cfg_addr`: 0 is the last index L, 1 is the sync offset, 2 is the divisor D, 3 is the mode (bit 0, 1 = pseudo-noise), and 4 is the seed. Pattern words are written with `mem_we` at word address `mem_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | 1 = play, 0 = stopped and rewound |
| rate_en | input | 1 | Bit-rate enable pulse |
| mem_we | input | 1 | Pattern word write strobe |
| mem_addr | input | $clog2(DEPTH) | Pattern word address |
| mem_wdata | input | WORD_W | Pattern word data |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration register select |
| cfg_wdata | input | max(index, DIV_W, LFSR_W) | Configuration write data |
| bit_out | output | 1 | Serial data bit |
| bit_valid | output | 1 | One-clock strobe for each new bit |
| sync_out | output | 1 | Scope trigger, one bit period wide |

## Verification
A table of runs varies the pattern length, the trigger offset and the divisor. The cases cover a pass spanning a word boundary, a short pass with a divided rate, a trigger on the last index, and an offset past the end. Together they separate index ordering, word and bit addressing, wrap point and trigger placement. Directed runs rewrite length and offset in mid-pass to expose an early commit, and write divisor and mode during play to show that those writes are ignored. Two pseudo-noise runs, one with the zero seed, are compared against an independent shift-register model. A stop in the middle of a pass checks the rewind and the quiet outputs.

// File: rtl/bitpat_pkg.sv
package bitpat_pkg;

   typedef enum logic [2:0] {
      REG_LAST = 3'd0,
      REG_SYNC = 3'd1,
      REG_DIV  = 3'd2,
      REG_MODE = 3'd3,
      REG_SEED = 3'd4
   } cfg_reg_e;

   function automatic int max3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/bitpat_store.sv
module bitpat_store #(
   parameter int WORD_W = 32,
   parameter int DEPTH  = 64,
   localparam int ADDR_W = $clog2(DEPTH),
   localparam int LSB_W  = $clog2(WORD_W),
   localparam int IDX_W  = ADDR_W + LSB_W
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [WORD_W-1:0] wdata,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic              rd_bit
);

   logic [WORD_W-1:0] words [DEPTH];
   logic [WORD_W-1:0] sel_word;

   always_ff @(posedge clk) begin
      if (we) words[waddr] <= wdata;
   end

   assign sel_word = words[rd_idx[IDX_W-1:LSB_W]];
   assign rd_bit   = sel_word[rd_idx[LSB_W-1:0]];

endmodule

// File: rtl/bitpat_seq.sv
module bitpat_seq #(
   parameter int IDX_W = 11,
   parameter int DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             rate_en,
   input  logic [IDX_W-1:0] cfg_last,
   input  logic [IDX_W-1:0] cfg_sync,
   input  logic [DIV_W-1:0] cfg_div,
   output logic             step,
   output logic [IDX_W-1:0] idx,
   output logic             at_sync
);

   logic [IDX_W-1:0] act_last, act_sync, cur;
   logic [DIV_W-1:0] act_div, cnt;
   logic             wrap_step;

   assign step      = run && rate_en && (cnt == act_div);
   assign wrap_step = step && (cur == act_last);
   assign idx       = cur;
   assign at_sync   = (cur == act_sync);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_last <= '0;
         act_sync <= '0;
         act_div  <= '0;
         cur      <= '0;
         cnt      <= '0;
      end else if (!run) begin
         cur      <= '0;
         cnt      <= '0;
         act_last <= cfg_last;
         act_sync <= cfg_sync;
         act_div  <= cfg_div;
      end else begin
         if (rate_en) cnt <= (cnt == act_div) ? '0 : cnt + 1'b1;
         if (wrap_step) begin
            cur      <= '0;
            act_last <= cfg_last;
            act_sync <= cfg_sync;
         end else if (step) begin
            cur <= cur + 1'b1;
         end
      end
   end

   assert_idx_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cur <= act_last);

   assert_div_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= act_div);

   assert_commit_at_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (run && $past(run) && !$past(wrap_step)) |-> ($stable(act_last) && $stable(act_sync)));

   assert_div_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (run && $past(run)) |-> $stable(act_div));

endmodule

// File: rtl/bitpat_pn.sv
module bitpat_pn #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] seed,
   input  logic         advance,
   output logic         out_bit
);

   logic [W-1:0] state;
   logic [W-1:0] mask;
   localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

   generate
      if (W == 8) begin : g_m8
         assign mask = 8'hB8;
      end else if (W == 16) begin : g_m16
         assign mask = 16'hB400;
      end else if (W == 24) begin : g_m24
         assign mask = 24'hE10000;
      end else if (W == 32) begin : g_m32
         assign mask = 32'h80200003;
      end else begin : g_bad
         $error("bitpat_pn: width must be 8, 16, 24 or 32");
         assign mask = '0;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)
         state <= ONE;
      else if (load)
         state <= (seed == '0) ? ONE : seed;
      else if (advance)
         state <= (state >> 1) ^ (state[0] ? mask : '0);
   end

   assign out_bit = state[0];

   assert_state_nonzero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      state != '0);

endmodule

// File: rtl/bitpat_gen.sv
module bitpat_gen #(
   parameter int WORD_W = 32,
   parameter int DEPTH  = 64,
   parameter int DIV_W  = 16,
   parameter int LFSR_W = 16,
   localparam int ADDR_W = $clog2(DEPTH),
   localparam int IDX_W  = ADDR_W + $clog2(WORD_W),
   localparam int CFG_W  = bitpat_pkg::max3(IDX_W, DIV_W, LFSR_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic              rate_en,
   input  logic              mem_we,
   input  logic [ADDR_W-1:0] mem_addr,
   input  logic [WORD_W-1:0] mem_wdata,
   input  logic              cfg_we,
   input  logic [2:0]        cfg_addr,
   input  logic [CFG_W-1:0]  cfg_wdata,
   output logic              bit_out,
   output logic              bit_valid,
   output logic              sync_out
);
   import bitpat_pkg::*;

   generate
      if (WORD_W < 2 || (WORD_W & (WORD_W - 1)) != 0) begin : g_chk_word
         $error("bitpat_gen: WORD_W must be a power of two");
      end
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_chk_depth
         $error("bitpat_gen: DEPTH must be a power of two of at least 2");
      end
      if (DIV_W < 1) begin : g_chk_div
         $error("bitpat_gen: DIV_W must be positive");
      end
   endgenerate

   logic [IDX_W-1:0]  reg_last, reg_sync;
   logic [DIV_W-1:0]  reg_div;
   logic              reg_mode;
   logic [LFSR_W-1:0] reg_seed;
   logic              pn_on;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         reg_last <= '0;
         reg_sync <= '0;
         reg_div  <= '0;
         reg_mode <= 1'b0;
         reg_seed <= {{(LFSR_W-1){1'b0}}, 1'b1};
      end else if (cfg_we) begin
         case (cfg_reg_e'(cfg_addr))
            REG_LAST: reg_last <= cfg_wdata[IDX_W-1:0];
            REG_SYNC: reg_sync <= cfg_wdata[IDX_W-1:0];
            REG_DIV:  reg_div  <= cfg_wdata[DIV_W-1:0];
            REG_MODE: reg_mode <= cfg_wdata[0];
            REG_SEED: reg_seed <= cfg_wdata[LFSR_W-1:0];
            default:  ;
         endcase
      end
   end

   logic             step, at_sync, mem_bit, pn_bit;
   logic [IDX_W-1:0] idx;

   bitpat_seq #(.IDX_W(IDX_W), .DIV_W(DIV_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .run(run), .rate_en(rate_en),
      .cfg_last(reg_last), .cfg_sync(reg_sync), .cfg_div(reg_div),
      .step(step), .idx(idx), .at_sync(at_sync)
   );

   bitpat_store #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_store (
      .clk(clk), .we(mem_we), .waddr(mem_addr), .wdata(mem_wdata),
      .rd_idx(idx), .rd_bit(mem_bit)
   );

   bitpat_pn #(.W(LFSR_W)) u_pn (
      .clk(clk), .rst_n(rst_n), .load(!run), .seed(reg_seed),
      .advance(step && pn_on), .out_bit(pn_bit)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pn_on     <= 1'b0;
         bit_out   <= 1'b0;
         bit_valid <= 1'b0;
         sync_out  <= 1'b0;
      end else if (!run) begin
         pn_on     <= reg_mode;
         bit_valid <= 1'b0;
         sync_out  <= 1'b0;
      end else if (step) begin
         bit_out   <= pn_on ? pn_bit : mem_bit;
         bit_valid <= 1'b1;
         sync_out  <= at_sync;
      end else begin
         bit_valid <= 1'b0;
      end
   end

   assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> (!bit_valid && !sync_out));

   assert_sync_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (run && $past(run) && !bit_valid) |-> ($stable(sync_out) && $stable(bit_out)));

   assert_mode_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (run && $past(run)) |-> $stable(pn_on));

endmodule

// File: tb/bitpat_gen_test.sv
`timescale 1ns/1ps
module bitpat_gen_test;
   localparam int WORD_W = 32;
   localparam int DEPTH  = 64;
   localparam int DIV_W  = 16;
   localparam int LFSR_W = 16;
   localparam int CFG_W  = 16;

   logic clk = 0, rst_n = 0, run = 0, rate_en = 0;
   logic mem_we = 0, cfg_we = 0;
   logic [5:0] mem_addr = '0;
   logic [31:0] mem_wdata = '0;
   logic [2:0] cfg_addr = '0;
   logic [CFG_W-1:0] cfg_wdata = '0;
   logic bit_out, bit_valid, sync_out;

   bitpat_gen #(.WORD_W(WORD_W), .DEPTH(DEPTH), .DIV_W(DIV_W), .LFSR_W(LFSR_W)) uut (
      .clk(clk), .rst_n(rst_n), .run(run), .rate_en(rate_en),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
      .bit_out(bit_out), .bit_valid(bit_valid), .sync_out(sync_out)
   );

   always #5 clk = ~clk;

   int checks = 0, errors = 0;
   bit done = 0;

   int m_idx, m_last, m_off, p_last, p_off, m_div;
   bit m_pn;
   logic [15:0] m_lfsr;

   // columns: last index, sync offset, divisor, bits to play
   localparam int VEC [4][4] = '{
      '{39, 5, 0, 90},
      '{7, 0, 1, 20},
      '{100, 100, 2, 110},
      '{15, 20, 0, 40}
   };

   function automatic logic [31:0] pat(input int k);
      logic [31:0] kk;
      kk = k;
      return (kk * 32'h9E3779B9) ^ 32'h5A5A0F0F;
   endfunction

   function automatic logic pat_bit(input int i);
      logic [31:0] w;
      w = pat(i / 32);
      return w[i % 32];
   endfunction

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk); #1;
   endtask

   task automatic cfg(input int a, input int d);
      cfg_addr = a[2:0]; cfg_wdata = d[CFG_W-1:0]; cfg_we = 1;
      tick();
      cfg_we = 0;
   endtask

   task automatic begin_run(input int last, input int off, input int div, input int pn, input int seed);
      run = 0;
      tick();
      cfg(0, last); cfg(1, off); cfg(2, div); cfg(3, pn); cfg(4, seed);
      tick(); tick();
      m_idx = 0; m_last = last; p_last = last; m_off = off; p_off = off;
      m_div = div; m_pn = (pn != 0);
      m_lfsr = (seed[15:0] == 16'h0) ? 16'h1 : seed[15:0];
      run = 1;
      tick();
   endtask

   task automatic model_next(output logic b, output logic s);
      b = m_pn ? m_lfsr[0] : pat_bit(m_idx);
      s = (m_idx == m_off);
      if (m_pn) m_lfsr = (m_lfsr >> 1) ^ (m_lfsr[0] ? 16'hB400 : 16'h0);
      if (m_idx == m_last) begin
         m_idx = 0; m_last = p_last; m_off = p_off;
      end else begin
         m_idx++;
      end
   endtask

   task automatic emit(input string btag);
      logic b, s;
      model_next(b, s);
      for (int p = 0; p < m_div; p++) begin
         rate_en = 1; tick(); rate_en = 0;
         check("R3 no bit before divisor count", int'(bit_valid), 0);
      end
      rate_en = 1; tick(); rate_en = 0;
      check("R3 bit_valid on qualifying pulse", int'(bit_valid), 1);
      check(btag, int'(bit_out), int'(b));
      check("R4 sync on offset bit", int'(sync_out), int'(s));
      tick();
      check("R3 bit_valid one clock", int'(bit_valid), 0);
      check("R4 sync held for bit period", int'(sync_out), int'(s));
      check("R4 bit held for bit period", int'(bit_out), int'(b));
   endtask

   task automatic summary();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL R3 watchdog actual=hung expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) tick();
      check("R1 bit_valid in reset", int'(bit_valid), 0);
      check("R1 sync_out in reset", int'(sync_out), 0);
      check("R1 bit_out in reset", int'(bit_out), 0);
      rst_n = 1;
      tick();
      check("R1 bit_valid after reset", int'(bit_valid), 0);
      check("R1 sync_out after reset", int'(sync_out), 0);

      for (int k = 0; k < DEPTH; k++) begin
         mem_we = 1; mem_addr = k[5:0]; mem_wdata = pat(k);
         tick();
      end
      mem_we = 0;

      // stimulus table: memory playback with varied length, offset, divisor
      for (int v = 0; v < 4; v++) begin
         begin_run(VEC[v][0], VEC[v][1], VEC[v][2], 0, 1);
         for (int n = 0; n < VEC[v][3]; n++) emit("R2/R9 stored bit order");
      end

      // R5: length and offset rewritten in mid-pass
      begin_run(31, 3, 0, 0, 1);
      for (int n = 0; n < 10; n++) emit("R5 before rewrite");
      cfg(0, 15); cfg(1, 2);
      p_last = 15; p_off = 2;
      for (int n = 0; n < 60; n++) emit("R5 commit at wrap");

      // R7: divisor and mode writes during play are ignored
      begin_run(20, 4, 0, 0, 1);
      cfg(2, 3); cfg(3, 1);
      for (int n = 0; n < 30; n++) emit("R7 rate and source unchanged");

      // R6: pseudo-noise with seed, then zero seed
      begin_run(50, 7, 0, 1, 16'hACE1);
      for (int n = 0; n < 80; n++) emit("R6 pn sequence");
      begin_run(9, 2, 1, 1, 0);
      for (int n = 0; n < 25; n++) emit("R6 zero seed forced to one");

      // R8: stop in mid-pass, sync held at stop time
      begin_run(63, 40, 0, 0, 1);
      for (int n = 0; n < 41; n++) emit("R2 before stop");
      check("R8 sync high before stop", int'(sync_out), 1);
      run = 0;
      tick();
      check("R8 sync_out cleared when stopped", int'(sync_out), 0);
      check("R8 bit_valid low when stopped", int'(bit_valid), 0);
      for (int p = 0; p < 3; p++) begin
         rate_en = 1; tick(); rate_en = 0;
         check("R8 rate_en ignored while stopped", int'(bit_valid), 0);
      end
      tick();
      m_idx = 0;
      run = 1;
      tick();
      for (int n = 0; n < 5; n++) emit("R8 restart from index 0");

      done = 1;
      summary();
      $finish;
   end

endmodule